// File: doc/BRIEF.md
# Bus-Width Matching Port

This block sits between a queue that stores only 36-bit long words and a port whose transfer width can be 36, 18 or 9 bits. On the read side it pulls one long word from the queue and hands it out as one, two or four narrow transfers. On the write side it gathers narrow transfers into one long word and commits that word to the queue only when the word is complete. The queue never sees a partial word.

The width and the lane order are chosen by a two-bit size select and an endianness select. Both are captured on every rising clock edge and govern the transfers on the edge after that, so the port can change width between any two transfers. The fourth size code marks a mailbox transfer, which bypasses this block: strobes in that mode touch neither the queue nor the lane state. If the width changes partway through a long word, the next transfer at the new width starts again at the first lane.

Narrow transfers always travel on the least significant lanes of the port bus. With the little-endian order, the first transfer of a long word carries its least significant group of lanes. With the big-endian order, the first transfer carries its most significant group.

Top module: `bwidth_port`

## Requirements
- R1: While reset is asserted, `rd_data` is zero and `fifo_push` is low. With no read strobe, `fifo_pop` is low. The stored selection after reset is 36-bit, little-endian.
- R2: `size_sel` is encoded as 00 = 36-bit, 01 = 18-bit, 10 = 9-bit and 11 = mailbox. `size_sel` and `big_end` are captured on every rising edge. A transfer on edge k uses the values captured on edge k-1.
- R3: In 36-bit mode, every read strobe raises `fifo_pop` in the cycle before the edge. After the edge, `rd_data` equals the whole word that was on `fifo_rdata`.
- R4: In 18-bit mode, a long word is read in two transfers. `fifo_pop` is high only on the first transfer. Each transfer puts its 18 bits on `rd_data[17:0]` and zeros on `rd_data[35:18]`.
- R5: In 9-bit mode, a long word is read in four transfers. `fifo_pop` is high only on the first transfer. Each transfer puts its byte on `rd_data[8:0]` and zeros on the upper bits.
- R6: In 36-bit mode, a write strobe on edge k makes `fifo_push` high for exactly one cycle after edge k, with `fifo_wdata` equal to `wr_data`.
- R7: In 18-bit and 9-bit modes, each write takes its data from the low 18 or 9 bits of `wr_data` and ignores the upper bits. `fifo_push` stays low until the final transfer of the long word. It then pulses once, with the packed word on `fifo_wdata`.
- R8: Lane order depends on `big_end`. With `big_end` = 0, transfer i of a long word maps to lane group i, counted from the least significant end. With `big_end` = 1, transfer i maps to lane group n-1-i, where n is the number of transfers per word. This holds for both reads and writes.
- R9: While the stored size is mailbox (11), read and write strobes raise neither `fifo_pop` nor `fifo_push`, and `rd_data` does not change.
- R10: The first transfer after a new size takes effect starts at the first lane. On the read side it pops a fresh long word. On the write side it drops any partly packed data.
- R11: `rd_data` holds its value in every cycle without an accepted read transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| size_sel | input | 2 | Transfer width select: 00 = 36, 01 = 18, 10 = 9, 11 = mailbox |
| big_end | input | 1 | 1 = most significant group first, 0 = least significant first |
| rd_stb | input | 1 | Read transfer on this edge |
| rd_data | output | 36 | Registered read data; narrow data sits on the low lanes |
| fifo_pop | output | 1 | Request to advance the read queue on this edge |
| fifo_rdata | input | 36 | Head long word of the read queue |
| wr_stb | input | 1 | Write transfer on this edge |
| wr_data | input | 36 | Write data; narrow data is taken from the low lanes |
| fifo_push | output | 1 | Registered request to commit `fifo_wdata` to the write queue |
| fifo_wdata | output | 36 | Packed long word for the write queue |

## Verification
The assertions assume the following about the environment:
- `fifo_rdata` always presents a valid head word whenever a read strobe arrives, and the write queue accepts every push, because the block has no empty or full inputs.
- The reset is released away from a clock edge, so no property looks back past it.

The bench keeps to these assumptions:
- Its queue model always holds a word and advances only on `fifo_pop`.
- It drives every input on the falling edge.
- It changes the selects only between transfers, except in the one test that deliberately changes the size on the same edge as a transfer to check the one-edge delay.

// File: rtl/bwidth_pkg.sv
package bwidth_pkg;

  typedef enum logic [1:0] {
    SZ_FULL = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_MBOX = 2'b11
  } bw_size_e;

endpackage

// File: rtl/bwidth_mode.sv
module bwidth_mode
  import bwidth_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] size_sel,
  input  logic       big_end,
  output bw_size_e   sz,
  output logic       be,
  output logic       restart
);

  bw_size_e sz_q, sz_d, szp_q, szp_d;
  logic     be_q, be_d;

  always_comb begin
    sz_d  = bw_size_e'(size_sel);
    be_d  = big_end;
    szp_d = sz_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sz_q  <= SZ_FULL;
      szp_q <= SZ_FULL;
      be_q  <= 1'b0;
    end else begin
      sz_q  <= sz_d;
      szp_q <= szp_d;
      be_q  <= be_d;
    end
  end

  assign sz      = sz_q;
  assign be      = be_q;
  assign restart = (sz_q != szp_q);

  // R2
  sel_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n)) |-> (sz_q == bw_size_e'($past(size_sel)) && be_q == $past(big_end)));

endmodule

// File: rtl/bwidth_lane_ctr.sv
module bwidth_lane_ctr
  import bwidth_pkg::*;
#(
  parameter  int LANES = 4,
  localparam int LG    = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bw_size_e      sz,
  input  logic          be,
  input  logic          restart,
  input  logic          stb,
  output logic          active,
  output logic          is_first,
  output logic          is_last,
  output logic [LG-1:0] pos,
  output logic [LG:0]   glog
);

  logic [LG-1:0] cnt_q, cnt_d, eff, last_idx;
  int            nlog;

  always_comb begin
    case (sz)
      SZ_HALF: nlog = 1;
      SZ_BYTE: nlog = LG;
      default: nlog = 0;
    endcase
    last_idx = LG'((1 << nlog) - 1);
    eff      = restart ? '0 : cnt_q;
    active   = stb && (sz != SZ_MBOX);
    is_first = (eff == '0);
    is_last  = (eff == last_idx);
    pos      = be ? (last_idx - eff) : eff;
    glog     = (LG+1)'(LG - nlog);
    cnt_d    = cnt_q;
    if (active)       cnt_d = is_last ? '0 : (eff + LG'(1));
    else if (restart) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  full_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sz == SZ_FULL && !restart) |-> (cnt_q == '0));

endmodule

// File: rtl/bwidth_unpack.sv
module bwidth_unpack #(
  parameter  int LANE_W = 9,
  parameter  int LANES  = 4,
  localparam int LG     = $clog2(LANES),
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              is_first,
  input  logic              is_last,
  input  logic [LG-1:0]     pos,
  input  logic [LG:0]       glog,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic [WORD_W-1:0] rd_data,
  output logic              fifo_pop
);

  logic [WORD_W-1:0] hold_q, src, rd_d, rd_q;
  logic              hold_en, rd_en;

  assign src      = is_first ? fifo_rdata : hold_q;
  assign fifo_pop = active && is_first;
  assign hold_en  = active && is_first && !is_last;
  assign rd_en    = active;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign rd_d[b*LANE_W +: LANE_W] = (b < (1 << glog))
      ? src[((int'(pos) << glog) + b) * LANE_W +: LANE_W]
      : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(rd_q));

endmodule

// File: rtl/bwidth_pack.sv
module bwidth_pack #(
  parameter  int LANE_W = 9,
  parameter  int LANES  = 4,
  localparam int LG     = $clog2(LANES),
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              is_first,
  input  logic              is_last,
  input  logic [LG-1:0]     pos,
  input  logic [LG:0]       glog,
  input  logic [WORD_W-1:0] wr_data,
  output logic              fifo_push,
  output logic [WORD_W-1:0] fifo_wdata
);

  logic [WORD_W-1:0] acc_q, acc_d, base, merged, wd_q;
  logic              push_q, push_d, acc_en, wd_en;

  assign base = is_first ? '0 : acc_q;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[b*LANE_W +: LANE_W] = ((b >> glog) == int'(pos))
      ? wr_data[(b & ((1 << glog) - 1)) * LANE_W +: LANE_W]
      : base[b*LANE_W +: LANE_W];
  end

  always_comb begin
    acc_en = active;
    acc_d  = is_last ? '0 : merged;
    wd_en  = active && is_last;
    push_d = active && is_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wd_q <= '0;
    else if (wd_en) wd_q <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) push_q <= 1'b0;
    else        push_q <= push_d;
  end

  assign fifo_push  = push_q;
  assign fifo_wdata = wd_q;

  // R7
  no_early_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !is_last) |=> !push_q);

endmodule

// File: rtl/bwidth_port.sv
module bwidth_port
  import bwidth_pkg::*;
#(
  parameter  int LANE_W = 9,
  parameter  int LANES  = 4,
  localparam int LG     = $clog2(LANES),
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        size_sel,
  input  logic              big_end,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] rd_data,
  output logic              fifo_pop,
  input  logic [WORD_W-1:0] fifo_rdata,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_data,
  output logic              fifo_push,
  output logic [WORD_W-1:0] fifo_wdata
);

  bw_size_e      sz;
  logic          be, restart;
  logic          r_act, r_first, r_last, w_act, w_first, w_last;
  logic [LG-1:0] r_pos, w_pos;
  logic [LG:0]   r_glog, w_glog;

  bwidth_mode u_mode (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .big_end(big_end),
    .sz(sz), .be(be), .restart(restart)
  );

  bwidth_lane_ctr #(.LANES(LANES)) u_rctr (
    .clk(clk), .rst_n(rst_n), .sz(sz), .be(be), .restart(restart), .stb(rd_stb),
    .active(r_act), .is_first(r_first), .is_last(r_last), .pos(r_pos), .glog(r_glog)
  );

  bwidth_lane_ctr #(.LANES(LANES)) u_wctr (
    .clk(clk), .rst_n(rst_n), .sz(sz), .be(be), .restart(restart), .stb(wr_stb),
    .active(w_act), .is_first(w_first), .is_last(w_last), .pos(w_pos), .glog(w_glog)
  );

  bwidth_unpack #(.LANE_W(LANE_W), .LANES(LANES)) u_rd (
    .clk(clk), .rst_n(rst_n), .active(r_act), .is_first(r_first), .is_last(r_last),
    .pos(r_pos), .glog(r_glog), .fifo_rdata(fifo_rdata),
    .rd_data(rd_data), .fifo_pop(fifo_pop)
  );

  bwidth_pack #(.LANE_W(LANE_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .active(w_act), .is_first(w_first), .is_last(w_last),
    .pos(w_pos), .glog(w_glog), .wr_data(wr_data),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata)
  );

  // R9
  mbox_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sz == SZ_MBOX) |-> !fifo_pop);

  // R9
  mbox_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sz == SZ_MBOX && wr_stb) |=> !fifo_push);

  // R10
  restart_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && rd_stb && sz != SZ_MBOX) |-> fifo_pop);

endmodule

// File: tb/sim_bwidth_port.sv
`timescale 1ns/1ps
module sim_bwidth_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_sel = 2'b00;
  logic        big_end = 1'b0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data, fifo_rdata, fifo_wdata;
  logic        fifo_pop, fifo_push;

  int checks = 0;
  int errors = 0;
  int head = 0;
  int exp_idx = 0;
  logic [35:0] cur;

  always #2 clk = ~clk;

  bwidth_port u0 (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .big_end(big_end),
    .rd_stb(rd_stb), .rd_data(rd_data), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
    .wr_stb(wr_stb), .wr_data(wr_data), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata)
  );

  function automatic logic [35:0] wd(int i);
    return {4'(i + 3), 8'(17 * (i + 1)), 8'(43 + i), 8'(196 ^ i), 8'(94 + 3 * i)};
  endfunction

  function automatic logic [35:0] sl(logic [35:0] w, int pos, int gb);
    logic [35:0] m;
    m = (gb == 4) ? '1 : ((36'd1 << (gb * 9)) - 36'd1);
    return (w >> (pos * gb * 9)) & m;
  endfunction

  assign fifo_rdata = wd(head);
  always @(posedge clk) if (rst_n && fifo_pop === 1'b1) head <= head + 1;

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic [1:0] s, logic b);
    size_sel = s;
    big_end  = b;
    @(negedge clk);
  endtask

  task automatic rd_xfer(bit exp_pop, int pos, int gb, string req);
    rd_stb = 1'b1;
    #1;
    chk({req, " pop"}, 36'(fifo_pop), 36'(exp_pop));
    if (exp_pop) begin
      cur = wd(exp_idx);
      exp_idx++;
    end
    @(negedge clk);
    rd_stb = 1'b0;
    chk({req, " data"}, rd_data, sl(cur, pos, gb));
  endtask

  task automatic wr_xfer(logic [35:0] d, bit exp_push, logic [35:0] exp_w, string req);
    wr_stb  = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    chk({req, " push"}, 36'(fifo_push), 36'(exp_push));
    if (exp_push) chk({req, " wdata"}, fifo_wdata, exp_w);
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, '0);
    chk("R1 push", 36'(fifo_push), '0);
    chk("R1 pop", 36'(fifo_pop), '0);
  endtask

  task automatic t_full_rd;
    rd_xfer(1, 0, 4, "R3 word0");
    rd_xfer(1, 0, 4, "R3 word1");
  endtask

  task automatic t_half_rd;
    set_mode(2'b01, 1'b0);
    rd_xfer(1, 0, 2, "R4 le first");
    rd_xfer(0, 1, 2, "R4 le second");
    set_mode(2'b01, 1'b1);
    rd_xfer(1, 1, 2, "R8 R4 be first");
    rd_xfer(0, 0, 2, "R8 R4 be second");
  endtask

  task automatic t_byte_rd;
    set_mode(2'b10, 1'b0);
    for (int i = 0; i < 4; i++) rd_xfer(i == 0, i, 1, "R5 le");
    set_mode(2'b10, 1'b1);
    for (int i = 0; i < 4; i++) rd_xfer(i == 0, 3 - i, 1, "R8 R5 be");
    set_mode(2'b10, 1'b0);
  endtask

  task automatic t_hold;
    logic [35:0] prev;
    prev = rd_data;
    repeat (3) @(negedge clk);
    chk("R11 idle hold", rd_data, prev);
  endtask

  task automatic t_timing;
    size_sel = 2'b01;
    rd_xfer(1, 0, 1, "R2 old size on sampling edge");
    rd_xfer(1, 0, 2, "R10 rd restart");
    rd_xfer(0, 1, 2, "R10 rd second half");
  endtask

  task automatic t_mbox;
    logic [35:0] prev;
    set_mode(2'b11, 1'b0);
    prev = rd_data;
    rd_stb = 1'b1;
    #1;
    chk("R9 no pop", 36'(fifo_pop), '0);
    @(negedge clk);
    rd_stb = 1'b0;
    chk("R9 rd_data kept", rd_data, prev);
    wr_xfer(36'h9_8765_4321, 0, '0, "R9 no push");
  endtask

  task automatic t_full_wr;
    set_mode(2'b00, 1'b0);
    wr_xfer(36'hA_BCDE_F012, 1, 36'hA_BCDE_F012, "R6 full");
    @(negedge clk);
    chk("R6 single pulse", 36'(fifo_push), '0);
  endtask

  task automatic t_half_wr;
    logic [17:0] a, b;
    a = 18'h2_1234;
    b = 18'h1_ABCD;
    set_mode(2'b01, 1'b0);
    wr_xfer({18'h3_FFFF, a}, 0, '0, "R7 le half one");
    wr_xfer({18'h2_AAAA, b}, 1, {b, a}, "R7 le half two");
    set_mode(2'b01, 1'b1);
    wr_xfer({18'h1_5555, a}, 0, '0, "R8 R7 be half one");
    wr_xfer({18'h0_0F0F, b}, 1, {a, b}, "R8 R7 be half two");
  endtask

  task automatic t_byte_wr;
    logic [8:0] e [4];
    e[0] = 9'h101; e[1] = 9'h0A2; e[2] = 9'h1C3; e[3] = 9'h054;
    set_mode(2'b10, 1'b0);
    for (int i = 0; i < 3; i++) wr_xfer({27'h7FF_FFFF, e[i]}, 0, '0, "R7 le byte");
    wr_xfer({27'h555_5555, e[3]}, 1, {e[3], e[2], e[1], e[0]}, "R7 le byte last");
    set_mode(2'b10, 1'b1);
    for (int i = 0; i < 3; i++) wr_xfer({27'h0, e[i]}, 0, '0, "R8 R7 be byte");
    wr_xfer({27'h0, e[3]}, 1, {e[0], e[1], e[2], e[3]}, "R8 R7 be byte last");
  endtask

  task automatic t_restart_wr;
    set_mode(2'b01, 1'b0);
    wr_xfer({18'h0, 18'h3_3333}, 0, '0, "R10 partial half");
    set_mode(2'b10, 1'b0);
    wr_xfer({27'h0, 9'h011}, 0, '0, "R10 byte0");
    wr_xfer({27'h0, 9'h022}, 0, '0, "R10 byte1");
    wr_xfer({27'h0, 9'h033}, 0, '0, "R10 byte2");
    wr_xfer({27'h0, 9'h044}, 1, {9'h044, 9'h033, 9'h022, 9'h011}, "R10 wr restart");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full_rd();
    t_half_rd();
    t_byte_rd();
    t_hold();
    t_timing();
    t_mbox();
    t_full_wr();
    t_half_wr();
    t_byte_wr();
    t_restart_wr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule